// File: doc/BRIEF.md
# Privilege-Mode Segment Address Checker

This block sits in front of the address translation path. Each request carries a 32-bit virtual address, a load/store flag, the 2-bit privilege field from the status register and the error-level and exception-level bits. The block classifies the request into one of three results. An address can fall in a fixed unmapped window, in which case the block returns the physical address and a cacheability flag. It can need translation, in which case the block passes the virtual address to the TLB. Or it can be a privilege violation, in which case the block raises an address-error fault whose type depends on the access.

First the block works out the effective privilege mode. Either status level bit forces kernel mode, and so does the reserved field value. The window rules of that mode then decide the class. Kernel mode has two direct windows that share the same physical base and differ only in cacheability. The decision is combinational. An optional output register, selected by a parameter, gives one cycle of latency.

Top module: `seg_addr_check`

## Requirements
- R1: When erl_i or exl_i is 1, the request is classified as kernel mode whatever the value of ksu_i.
- R2: A ksu_i value of 3 is treated as kernel mode. The other encodings are 0 = kernel, 1 = supervisor and 2 = user.
- R3: In kernel mode, an address from 0x80000000 to 0x9FFFFFFF gives unmapped_o=1 and cached_o=1, with paddr_o = vaddr − 0x80000000.
- R4: In kernel mode, an address from 0xA0000000 to 0xBFFFFFFF gives unmapped_o=1 and cached_o=0, with paddr_o = vaddr − 0xA0000000.
- R5: In kernel mode, every address outside those two windows gives mapped_o=1, with tlb_vaddr_o equal to the virtual address.
- R6: In supervisor mode, an address whose bits [31:29] are 000 or 110 gives mapped_o=1. Any other address gives fault_o=1.
- R7: In user mode, an address with bit 31 set gives fault_o=1. Any other address gives mapped_o=1.
- R8: A fault sets fault_load_o when is_store_i=0 and fault_store_o when is_store_i=1, never both. Both are 0 when there is no fault.
- R9: A valid request sets exactly one of unmapped_o, mapped_o and fault_o. With req_valid_i=0 all three are 0. paddr_o and cached_o are 0 unless unmapped_o=1, and tlb_vaddr_o is 0 unless mapped_o=1.
- R10: With REG_OUT=1 (the default), the outputs reflect the inputs one clock edge later. An active-low asynchronous reset clears every output to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| vaddr_i | input | 32 | Virtual address |
| is_store_i | input | 1 | 1 for a store, 0 for a load |
| ksu_i | input | 2 | Privilege field: 0 kernel, 1 supervisor, 2 user, 3 reserved |
| erl_i | input | 1 | Error-level status bit |
| exl_i | input | 1 | Exception-level status bit |
| unmapped_o | output | 1 | Address lies in an unmapped kernel window |
| mapped_o | output | 1 | TLB translation request |
| fault_o | output | 1 | Address-error fault |
| fault_load_o | output | 1 | Fault on a load |
| fault_store_o | output | 1 | Fault on a store |
| cached_o | output | 1 | Unmapped window is cacheable |
| paddr_o | output | 32 | Physical address for an unmapped access |
| tlb_vaddr_o | output | 32 | Virtual address handed to the TLB |

## Verification
The hardest situations to reach are the ones where ksu_i says one thing and the effective mode is another. One case is a user-mode field combined with a set status level bit. In that case an address that would fault in user mode has to come out unmapped or mapped instead. The other case is the reserved field value. The vector table sets ksu_i to user or supervisor together with erl_i or exl_i, and to 3 on its own, at addresses that give a different result in each mode. The table also places addresses on the window edges (0x9FFFFFFC, 0xA0000000, 0xBFFFFFFF, 0xC0000000, 0xE0000000), where a single wrong bit in the decode moves the request into the neighbouring class.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int unsigned VA_W  = 32;
  localparam int unsigned TOP_W = 3;   // address bits that select a segment

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_USER = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef struct packed {
    logic            unmapped;
    logic            mapped;
    logic            flt_ld;
    logic            flt_st;
    logic            cached;
    logic [VA_W-1:0] paddr;
    logic [VA_W-1:0] tlb_va;
  } seg_res_t;
endpackage

// File: rtl/seg_mode_resolve.sv
module seg_mode_resolve
  import seg_chk_pkg::*;
(
  input  logic [1:0] ksu_i,
  input  logic       erl_i,
  input  logic       exl_i,
  output mode_e      eff_mode_o
);
  always_comb begin
    if (erl_i || exl_i) eff_mode_o = MODE_KERN;
    else begin
      unique case (ksu_i)
        2'd1:    eff_mode_o = MODE_SUPV;
        2'd2:    eff_mode_o = MODE_USER;
        default: eff_mode_o = MODE_KERN;  // reserved value folds to kernel
      endcase
    end
  end
endmodule

// File: rtl/seg_window_decode.sv
module seg_window_decode
  import seg_chk_pkg::*;
(
  input  logic            valid_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            is_store_i,
  input  mode_e           mode_i,
  output seg_res_t        res_o
);
  localparam int unsigned OFS_W = VA_W - TOP_W;

  logic [TOP_W-1:0] top;
  logic             kwin;
  logic             ok;
  logic             flt;

  assign top  = vaddr_i[VA_W-1 -: TOP_W];
  // both direct kernel windows share the 10x prefix
  assign kwin = (mode_i == MODE_KERN) && (top[TOP_W-1 -: 2] == 2'b10);

  always_comb begin
    unique case (mode_i)
      MODE_SUPV: ok = (top == 3'b000) || (top == 3'b110);
      MODE_USER: ok = !vaddr_i[VA_W-1];
      default:   ok = 1'b1;
    endcase
  end

  assign flt = valid_i && !ok;

  always_comb begin
    res_o          = '0;
    res_o.unmapped = valid_i && kwin;
    res_o.mapped   = valid_i && ok && !kwin;
    res_o.flt_ld   = flt && !is_store_i;
    res_o.flt_st   = flt && is_store_i;
    if (res_o.unmapped) begin
      res_o.cached = !vaddr_i[OFS_W];
      res_o.paddr  = {{TOP_W{1'b0}}, vaddr_i[OFS_W-1:0]};
    end
    if (res_o.mapped) res_o.tlb_va = vaddr_i;
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_chk_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  seg_res_t d_i,
  output seg_res_t q_o
);
  if (REG_OUT) begin : g_reg
    seg_res_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d_i;
    end
    assign q_o = q;
  end else begin : g_comb
    assign q_o = rst_ni ? d_i : '0;
  end
endmodule

// File: rtl/seg_addr_check.sv
module seg_addr_check
  import seg_chk_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            is_store_i,
  input  logic [1:0]      ksu_i,
  input  logic            erl_i,
  input  logic            exl_i,
  output logic            unmapped_o,
  output logic            mapped_o,
  output logic            fault_o,
  output logic            fault_load_o,
  output logic            fault_store_o,
  output logic            cached_o,
  output logic [VA_W-1:0] paddr_o,
  output logic [VA_W-1:0] tlb_vaddr_o
);
  mode_e    eff_mode;
  seg_res_t res_d;
  seg_res_t res_q;

  seg_mode_resolve u_mode (
    .ksu_i      (ksu_i),
    .erl_i      (erl_i),
    .exl_i      (exl_i),
    .eff_mode_o (eff_mode)
  );

  seg_window_decode u_dec (
    .valid_i    (req_valid_i),
    .vaddr_i    (vaddr_i),
    .is_store_i (is_store_i),
    .mode_i     (eff_mode),
    .res_o      (res_d)
  );

  seg_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (res_d),
    .q_o    (res_q)
  );

  assign unmapped_o    = res_q.unmapped;
  assign mapped_o      = res_q.mapped;
  assign fault_load_o  = res_q.flt_ld;
  assign fault_store_o = res_q.flt_st;
  assign fault_o       = res_q.flt_ld | res_q.flt_st;
  assign cached_o      = res_q.cached;
  assign paddr_o       = res_q.paddr;
  assign tlb_vaddr_o   = res_q.tlb_va;
endmodule

// File: rtl/seg_addr_check_sva.sv
module seg_addr_check_sva #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] vaddr_i,
  input logic        is_store_i,
  input logic [1:0]  ksu_i,
  input logic        erl_i,
  input logic        exl_i,
  input logic        unmapped_o,
  input logic        mapped_o,
  input logic        fault_o,
  input logic        fault_load_o,
  input logic        fault_store_o,
  input logic        cached_o,
  input logic [31:0] paddr_o,
  input logic [31:0] tlb_vaddr_o
);
  a_r9_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({unmapped_o, mapped_o, fault_o}) <= 1);

  a_r8_fault_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($countones({fault_load_o, fault_store_o}) == 1));

  a_r3_window_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> (paddr_o[31:29] == 3'b000));

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unmapped_o |-> (paddr_o == '0 && !cached_o));

  a_r5_tlb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped_o |-> (tlb_vaddr_o == '0));

  if (REG_OUT) begin : g_seq
    a_r1_forced_kernel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && (erl_i || exl_i)) |=> !fault_o);
    a_r7_user_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && ksu_i == 2'd2 && !erl_i && !exl_i && vaddr_i[31]) |=> fault_o);
    a_r9_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> !(unmapped_o || mapped_o || fault_o));
  end else begin : g_cmb
    a_r1_forced_kernel: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && (erl_i || exl_i)) |-> !fault_o);
    a_r7_user_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && ksu_i == 2'd2 && !erl_i && !exl_i && vaddr_i[31]) |-> fault_o);
    a_r9_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |-> !(unmapped_o || mapped_o || fault_o));
  end
endmodule

bind seg_addr_check seg_addr_check_sva #(.REG_OUT(REG_OUT)) u_sva (.*);

// File: tb/seg_addr_check_tb_top.sv
module seg_addr_check_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic        is_store_i = 1'b0;
  logic [1:0]  ksu_i = '0;
  logic        erl_i = 1'b0;
  logic        exl_i = 1'b0;
  logic        unmapped_o, mapped_o, fault_o, fault_load_o, fault_store_o, cached_o;
  logic [31:0] paddr_o, tlb_vaddr_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  seg_addr_check dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .vaddr_i(vaddr_i),
    .is_store_i(is_store_i), .ksu_i(ksu_i), .erl_i(erl_i), .exl_i(exl_i),
    .unmapped_o(unmapped_o), .mapped_o(mapped_o), .fault_o(fault_o),
    .fault_load_o(fault_load_o), .fault_store_o(fault_store_o), .cached_o(cached_o),
    .paddr_o(paddr_o), .tlb_vaddr_o(tlb_vaddr_o)
  );

  // cls: 1 unmapped, 2 mapped, 3 fault
  typedef struct packed {
    logic [31:0] va;
    logic        st;
    logic [1:0]  ksu;
    logic        erl;
    logic        exl;
    logic [1:0]  cls;
    logic        cch;
    logic [31:0] pa;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h80001234, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 32'h00001234, 4'd3},  // R3
    '{32'h9FFFFFFC, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1, 32'h1FFFFFFC, 4'd3},  // R3 top edge
    '{32'hA0000000, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 32'h00000000, 4'd4},  // R4 low edge
    '{32'hBFFFFFFF, 1'b1, 2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 32'h1FFFFFFF, 4'd4},  // R4 top edge
    '{32'h7FFFFFFF, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 32'h0,        4'd5},  // R5
    '{32'hC0000000, 1'b1, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0, 32'h0,        4'd5},  // R5
    '{32'h12345678, 1'b0, 2'd1, 1'b0, 1'b0, 2'd2, 1'b0, 32'h0,        4'd6},  // R6 top 000
    '{32'hC0000010, 1'b1, 2'd1, 1'b0, 1'b0, 2'd2, 1'b0, 32'h0,        4'd6},  // R6 top 110
    '{32'h80000000, 1'b0, 2'd1, 1'b0, 1'b0, 2'd3, 1'b0, 32'h0,        4'd6},  // R6 load fault
    '{32'hE0000000, 1'b1, 2'd1, 1'b0, 1'b0, 2'd3, 1'b0, 32'h0,        4'd6},  // R6 store fault
    '{32'h40000000, 1'b0, 2'd1, 1'b0, 1'b0, 2'd3, 1'b0, 32'h0,        4'd6},  // R6 top 010
    '{32'h7FFFFFFF, 1'b0, 2'd2, 1'b0, 1'b0, 2'd2, 1'b0, 32'h0,        4'd7},  // R7
    '{32'h80000000, 1'b1, 2'd2, 1'b0, 1'b0, 2'd3, 1'b0, 32'h0,        4'd8},  // R8 store
    '{32'hA0000000, 1'b0, 2'd2, 1'b0, 1'b1, 2'd1, 1'b0, 32'h00000000, 4'd1},  // R1 exl
    '{32'hFFFFFFF0, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0, 32'h0,        4'd1},  // R1 erl
    '{32'h90000000, 1'b1, 2'd1, 1'b0, 1'b1, 2'd1, 1'b1, 32'h10000000, 4'd1},  // R1 supv
    '{32'h80000010, 1'b0, 2'd3, 1'b0, 1'b0, 2'd1, 1'b1, 32'h00000010, 4'd2},  // R2
    '{32'hE0000000, 1'b1, 2'd3, 1'b0, 1'b0, 2'd2, 1'b0, 32'h0,        4'd2},  // R2
    '{32'h00000000, 1'b0, 2'd2, 1'b0, 1'b0, 2'd2, 1'b0, 32'h0,        4'd7}   // R7
  };

  function automatic logic [69:0] observed();
    return {unmapped_o, mapped_o, fault_load_o, fault_store_o, fault_o, cached_o, paddr_o, tlb_vaddr_o};
  endfunction

  task automatic check(input string tag, input logic [69:0] exp);
    checks++;
    if (observed() !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, observed(), exp);
    end
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [69:0] e;
    // R10: reset state
    repeat (3) @(posedge clk);
    #1 check("R10 reset", '0);
    @(negedge clk) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid_i = 1'b1;
      vaddr_i = VECS[i].va; is_store_i = VECS[i].st; ksu_i = VECS[i].ksu;
      erl_i = VECS[i].erl; exl_i = VECS[i].exl;
      @(posedge clk); #1;
      e = '0;
      e[69] = (VECS[i].cls == 2'd1);
      e[68] = (VECS[i].cls == 2'd2);
      e[67] = (VECS[i].cls == 2'd3) && !VECS[i].st;
      e[66] = (VECS[i].cls == 2'd3) && VECS[i].st;
      e[65] = (VECS[i].cls == 2'd3);
      e[64] = VECS[i].cch;
      e[63:32] = VECS[i].pa;
      e[31:0] = (VECS[i].cls == 2'd2) ? VECS[i].va : 32'h0;
      check($sformatf("R%0d vec%0d", VECS[i].rq, i), e);
    end

    // R9: no request -> all quiet even for a faulting address
    @(negedge clk);
    req_valid_i = 1'b0; vaddr_i = 32'h80000000; ksu_i = 2'd2; erl_i = 0; exl_i = 0;
    @(posedge clk); #1 check("R9 idle", '0);

    // R10: one cycle latency
    @(negedge clk);
    req_valid_i = 1'b1; vaddr_i = 32'h80000004; ksu_i = 2'd0; is_store_i = 1'b0;
    #1 check("R10 before edge", '0);
    @(posedge clk); #1;
    e = '0; e[69] = 1'b1; e[64] = 1'b1; e[63:32] = 32'h4;
    check("R10 after edge", e);

    // R10: asynchronous reset clears at once
    @(negedge clk) rst_ni = 1'b0;
    #1 check("R10 async reset", '0);
    @(negedge clk) rst_ni = 1'b1; req_valid_i = 1'b0;
    @(posedge clk); #1 check("R9 after reset idle", '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule